// File: doc/BRIEF.md
# External Memory Bus Cycle Sequencer

This block produces the multiplexed external bus waveforms for an 8-bit controller core: the address latch strobe, the active-low program-store strobe, the active-low read and write strobes, and the drive values and enables for the low (address/data) port and the high (address) port. It runs on the oscillator clock and divides it into machine cycles of 12 clocks, or 6 clocks in double-speed mode. Every strobe edge sits at a fixed oscillator slot within the machine cycle.

The core presents a request: a kind (idle, code fetch, data read, data write), a 16-bit address and a write byte. The request is taken only in the last clock of a machine cycle and runs for the whole of the next machine cycle. A code fetch reads two consecutive bytes, one in each half of the cycle. A data access uses one machine cycle with a single long read or write strobe. Bytes read from the low port are captured on the clock edge that ends the strobe, and a one-clock completion pulse follows the cycle.

Top module: `xbus_cycle_seq`

## Requirements
- R1: A machine cycle is 12 clocks when `dblSpeed` is 0 and 6 clocks when it is 1. The mode is sampled only at a machine-cycle boundary. Slot s runs 0..11: in 12-clock mode clock k is slot k, and in 6-clock mode clock k is slot 2k.
- R2: `reqTake` is high only in the final clock of a machine cycle while `reqValid` is high, and the request runs in the following cycle. `busDone` is high for exactly the first clock after a non-idle cycle and low after an idle one.
- R3: `ale` is high in slots 0-1 and 6-7, giving 2 clocks per pulse in 12-clock mode. The low address byte is driven on port 0 in slots 0-2 of each half, which holds it one slot past the fall of `ale`.
- R4: For a code fetch with `extExec`=1, `psenN` is low in slots 3-5 and 9-11. Port 0 carries the address byte `addr` in the lower half and `addr+1` in the upper half.
- R5: For a code fetch with `extExec`=0, `psenN` stays high, neither port is driven, and the captured data is left unchanged.
- R6: During a data read or write, `psenN` stays high and the `ale` pulse in slots 6-7 is skipped.
- R7: `rdN` (read, kind 2) or `wrN` (write, kind 3) is low in slots 5-10. That is 6 clocks starting 3 clocks after `ale` falls. In 12-clock mode `ale` rises again one clock after the strobe returns high.
- R8: For a write, port 0 carries the write byte in slots 3-11, which is at least 7 clocks before `wrN` rises in 12-clock mode.
- R9: When `aleOff` is 1, `ale` is held low. All other outputs are unchanged.
- R10: For any external access, port 2 is driven for the whole cycle with bits 15:8 of the address. In the upper half of a fetch it carries bits 15:8 of `addr+1`.
- R11: Port 0 output is disabled whenever `psenN` or `rdN` is low.
- R12: `rdData` is {byte at addr+1, byte at addr} after an external fetch and {8'h00, byte} after a data read. Each byte is taken from `p0In` on the edge that ends its strobe.

Request kind encoding: 0 idle, 1 code fetch, 2 data read, 3 data write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dblSpeed | input | 1 | 1 selects 6-clock machine cycles |
| extExec | input | 1 | 1 fetches code from the external bus |
| aleOff | input | 1 | 1 holds the address latch strobe low |
| reqValid | input | 1 | A request is presented |
| reqKind | input | 2 | Request kind (0 idle, 1 fetch, 2 read, 3 write) |
| reqAddr | input | 16 | Request address |
| reqWdata | input | 8 | Byte to write |
| p0In | input | 8 | Value read back from the low port |
| reqTake | output | 1 | Request taken at this boundary |
| busDone | output | 1 | One-clock pulse after a non-idle cycle |
| ale | output | 1 | Address latch strobe, active high |
| psenN | output | 1 | Program-store strobe, active low |
| rdN | output | 1 | Data read strobe, active low |
| wrN | output | 1 | Data write strobe, active low |
| p0Out | output | 8 | Low port drive value |
| p0Oe | output | 1 | Low port drive enable |
| p2Out | output | 8 | High port drive value |
| p2Oe | output | 1 | High port drive enable |
| rdData | output | 16 | Captured read or fetch bytes |

## Verification
The strobes and port values are decoded from the registered slot counter. They therefore change one clock after the boundary edge at which a request is taken, and the bench samples slot k at the k-th falling edge after that boundary. `reqTake` is combinational, so it is checked at the falling edge of the final slot. `busDone` and `rdData` are due at the first falling edge of the next machine cycle, and they are checked there. All of these expected values are worked out arithmetically from the slot table for every mode, execution source, strobe-disable setting, kind and address in the sweep.

// File: rtl/xbus_seq_pkg.sv
package xbus_seq_pkg;

  // Slot schedule, expressed in 12-clock units
  localparam int CYC_SLOTS  = 12;
  localparam int HALF_SLOTS = CYC_SLOTS / 2;
  localparam int ALE_LAST   = 1;
  localparam int ADDR_LAST  = 2;
  localparam int PSEN_FIRST = 3;
  localparam int WD_FIRST   = 3;
  localparam int RW_FIRST   = 5;
  localparam int RW_LAST    = 10;

  typedef enum logic [1:0] {
    KIND_IDLE  = 2'd0,
    KIND_FETCH = 2'd1,
    KIND_READ  = 2'd2,
    KIND_WRITE = 2'd3
  } busKind_e;

  typedef struct packed {
    logic ale;
    logic psen;
    logic rd;
    logic wr;
    logic p0Addr;
    logic p0Wdata;
    logic p2Drive;
    logic upperHalf;
    logic capLo;
    logic capHi;
    logic capClr;
  } busStrobe_t;

endpackage

// File: rtl/xbus_seq_ctrl.sv
module xbus_seq_ctrl
  import xbus_seq_pkg::*;
#(
  parameter int SLOT_W = $clog2(CYC_SLOTS)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       dblSpeed,
  input  logic       extExec,
  input  logic       aleOff,
  input  logic       reqValid,
  input  busKind_e   reqKind,
  output logic       reqTake,
  output logic       busDone,
  output busStrobe_t strb
);

  localparam logic [SLOT_W:0]   CYC_END   = (SLOT_W+1)'(CYC_SLOTS);
  localparam logic [SLOT_W:0]   HALF_SUM  = (SLOT_W+1)'(HALF_SLOTS);
  localparam logic [SLOT_W:0]   RW_SUM    = (SLOT_W+1)'(RW_LAST);
  localparam logic [SLOT_W-1:0] S_HALF    = SLOT_W'(HALF_SLOTS);
  localparam logic [SLOT_W-1:0] S_ALE     = SLOT_W'(ALE_LAST);
  localparam logic [SLOT_W-1:0] S_ADDR    = SLOT_W'(ADDR_LAST);
  localparam logic [SLOT_W-1:0] S_PSEN    = SLOT_W'(PSEN_FIRST);
  localparam logic [SLOT_W-1:0] S_WD      = SLOT_W'(WD_FIRST);
  localparam logic [SLOT_W-1:0] S_RWFIRST = SLOT_W'(RW_FIRST);
  localparam logic [SLOT_W-1:0] S_RWLAST  = SLOT_W'(RW_LAST);

  logic [SLOT_W-1:0] slot;
  logic [SLOT_W-1:0] rel;
  logic [SLOT_W:0]   slotSum;
  logic              dblQ;
  logic              extQ;
  logic              doneQ;
  busKind_e          kindQ;
  logic              atEnd;
  logic              upper;
  logic              extFetch;
  logic              dataAcc;

  assign slotSum  = {1'b0, slot} + (dblQ ? (SLOT_W+1)'(2) : (SLOT_W+1)'(1));
  assign atEnd    = (slotSum == CYC_END);
  assign upper    = (slot >= S_HALF);
  assign rel      = upper ? (slot - S_HALF) : slot;
  assign extFetch = (kindQ == KIND_FETCH) && extQ;
  assign dataAcc  = (kindQ == KIND_READ) || (kindQ == KIND_WRITE);
  assign reqTake  = reqValid && atEnd;
  assign busDone  = doneQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slot  <= '0;
      dblQ  <= 1'b0;
      extQ  <= 1'b0;
      kindQ <= KIND_IDLE;
      doneQ <= 1'b0;
    end else begin
      doneQ <= atEnd && (kindQ != KIND_IDLE);
      if (atEnd) begin
        slot  <= '0;
        dblQ  <= dblSpeed;
        extQ  <= extExec;
        kindQ <= reqValid ? reqKind : KIND_IDLE;
      end else begin
        slot  <= slotSum[SLOT_W-1:0];
      end
    end
  end

  always_comb begin
    strb           = '0;
    strb.ale       = !aleOff && (rel <= S_ALE) && (!upper || !dataAcc);
    strb.psen      = extFetch && (rel >= S_PSEN);
    strb.rd        = (kindQ == KIND_READ)  && (slot >= S_RWFIRST) && (slot <= S_RWLAST);
    strb.wr        = (kindQ == KIND_WRITE) && (slot >= S_RWFIRST) && (slot <= S_RWLAST);
    strb.p0Addr    = (extFetch && (rel <= S_ADDR)) || (dataAcc && (slot <= S_ADDR));
    strb.p0Wdata   = (kindQ == KIND_WRITE) && (slot >= S_WD);
    strb.p2Drive   = extFetch || dataAcc;
    strb.upperHalf = extFetch && upper;
    strb.capClr    = (kindQ == KIND_READ) && (slot <= S_RWLAST) && (slotSum > RW_SUM);
    strb.capLo     = (extFetch && !upper && (slotSum >= HALF_SUM)) || strb.capClr;
    strb.capHi     = extFetch && atEnd;
  end

  // R1: slot stays in range and lands on even slots in 6-clock mode
  p_slot_range_r1: assert property (@(posedge clk) disable iff (!rstN)
    (slot < SLOT_W'(CYC_SLOTS)) && (!dblQ || !slot[0]));

  // R2: the completion pulse only appears in the first clock of a cycle
  p_done_boundary_r2: assert property (@(posedge clk) disable iff (!rstN)
    busDone |-> (slot == '0));

  // R7: in 12-clock mode a read strobe lasts exactly six clocks
  p_rd_width_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(strb.rd) && !dblQ) |-> ($past(strb.rd, 6) && !$past(strb.rd, 7)));

  // R7: address latch strobe returns one clock after a data strobe ends
  p_ale_after_rw_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(strb.rd || strb.wr) && !dblQ) |=> (strb.ale || aleOff));

endmodule

// File: rtl/xbus_seq_dp.sv
module xbus_seq_dp
  import xbus_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  busStrobe_t          strb,
  input  logic                reqLoad,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic [DATA_W-1:0]   p0In,
  output logic                ale,
  output logic                psenN,
  output logic                rdN,
  output logic                wrN,
  output logic [DATA_W-1:0]   p0Out,
  output logic                p0Oe,
  output logic [ADDR_W-DATA_W-1:0] p2Out,
  output logic                p2Oe,
  output logic [2*DATA_W-1:0] rdData
);

  localparam int HI_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] addrQ;
  logic [ADDR_W-1:0] addrSel;
  logic [DATA_W-1:0] wdQ;

  assign addrSel = strb.upperHalf ? (addrQ + ADDR_W'(1)) : addrQ;
  assign ale     = strb.ale;
  assign psenN   = !strb.psen;
  assign rdN     = !strb.rd;
  assign wrN     = !strb.wr;
  assign p0Oe    = strb.p0Addr || strb.p0Wdata;
  assign p0Out   = strb.p0Wdata ? wdQ : (strb.p0Addr ? addrSel[DATA_W-1:0] : '0);
  assign p2Oe    = strb.p2Drive;
  assign p2Out   = strb.p2Drive ? addrSel[ADDR_W-1:DATA_W] : HI_W'(0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdQ    <= '0;
      rdData <= '0;
    end else begin
      if (reqLoad) begin
        addrQ <= reqAddr;
        wdQ   <= reqWdata;
      end
      if (strb.capLo) rdData[DATA_W-1:0] <= p0In;
      if (strb.capHi) rdData[2*DATA_W-1:DATA_W] <= p0In;
      else if (strb.capClr) rdData[2*DATA_W-1:DATA_W] <= '0;
    end
  end

  // R11: the low port never drives while a read-type strobe is low
  p_float_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!psenN || !rdN) |-> !p0Oe);

  // R8: write byte is already on the port and steady while the write strobe is low
  p_wdata_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
    !wrN |-> (p0Oe && $stable(p0Out)));

endmodule

// File: rtl/xbus_cycle_seq.sv
module xbus_cycle_seq
  import xbus_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     dblSpeed,
  input  logic                     extExec,
  input  logic                     aleOff,
  input  logic                     reqValid,
  input  logic [1:0]               reqKind,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [DATA_W-1:0]        reqWdata,
  input  logic [DATA_W-1:0]        p0In,
  output logic                     reqTake,
  output logic                     busDone,
  output logic                     ale,
  output logic                     psenN,
  output logic                     rdN,
  output logic                     wrN,
  output logic [DATA_W-1:0]        p0Out,
  output logic                     p0Oe,
  output logic [ADDR_W-DATA_W-1:0] p2Out,
  output logic                     p2Oe,
  output logic [2*DATA_W-1:0]      rdData
);

  busStrobe_t strb;

  xbus_seq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .dblSpeed (dblSpeed),
    .extExec  (extExec),
    .aleOff   (aleOff),
    .reqValid (reqValid),
    .reqKind  (busKind_e'(reqKind)),
    .reqTake  (reqTake),
    .busDone  (busDone),
    .strb     (strb)
  );

  xbus_seq_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reqLoad  (reqTake),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .p0In     (p0In),
    .ale      (ale),
    .psenN    (psenN),
    .rdN      (rdN),
    .wrN      (wrN),
    .p0Out    (p0Out),
    .p0Oe     (p0Oe),
    .p2Out    (p2Out),
    .p2Oe     (p2Oe),
    .rdData   (rdData)
  );

endmodule

// File: tb/xbus_cycle_seq_tb.sv
`timescale 1ns/1ps
module xbus_cycle_seq_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        dblSpeed = 1'b0, extExec = 1'b0, aleOff = 1'b0, reqValid = 1'b0;
  logic [1:0]  reqKind = 2'd0;
  logic [15:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic [7:0]  p0In;
  logic        reqTake, busDone, ale, psenN, rdN, wrN, p0Oe, p2Oe;
  logic [7:0]  p0Out, p2Out;
  logic [15:0] rdData;

  int vectors = 0;
  int fails = 0;
  logic [7:0]  latchLo = '0;
  logic [15:0] expRd = '0;

  always #4 clk = ~clk;   // 125 MHz

  xbus_cycle_seq u_dut (
    .clk(clk), .rstN(rstN), .dblSpeed(dblSpeed), .extExec(extExec), .aleOff(aleOff),
    .reqValid(reqValid), .reqKind(reqKind), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .p0In(p0In), .reqTake(reqTake), .busDone(busDone), .ale(ale), .psenN(psenN),
    .rdN(rdN), .wrN(wrN), .p0Out(p0Out), .p0Oe(p0Oe), .p2Out(p2Out), .p2Oe(p2Oe),
    .rdData(rdData)
  );

  // External memory model: byte = high address ^ latched low address ^ 3C
  always @(posedge clk) if (p0Oe) latchLo <= p0Out;
  assign p0In = p2Out ^ latchLo ^ 8'h3C;

  function automatic logic [7:0] memByte(input logic [15:0] a);
    return a[15:8] ^ a[7:0] ^ 8'h3C;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %0h exp %0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic runCycle(input logic [1:0] kind, input logic [15:0] addr, input logic [7:0] wd,
                          input logic dbl, input logic ext, input logic aoff);
    int nClk;
    logic extF, dat, up, eAle, ePsen, eRd, eWr, eP0Oe, eP2Oe;
    logic [7:0] eP0, eP2;
    logic [15:0] a1, selA;
    int s, r;
    nClk = dbl ? 6 : 12;
    dblSpeed = dbl; extExec = ext; aleOff = aoff;
    reqKind = kind; reqAddr = addr; reqWdata = wd; reqValid = 1'b1;
    #1;
    while (!reqTake) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    a1 = addr + 16'd1;
    extF = (kind == 2'd1) && ext;
    dat = (kind == 2'd2) || (kind == 2'd3);
    for (int k = 0; k < nClk; k++) begin
      if (k > 0) @(negedge clk);
      s = dbl ? 2 * k : k;
      up = (s >= 6);
      r = up ? s - 6 : s;
      selA = (extF && up) ? a1 : addr;
      eAle  = !aoff && (r <= 1) && (!up || !dat);
      ePsen = extF && (r >= 3);
      eRd   = (kind == 2'd2) && (s >= 5) && (s <= 10);
      eWr   = (kind == 2'd3) && (s >= 5) && (s <= 10);
      eP0Oe = (extF && r <= 2) || (dat && s <= 2) || ((kind == 2'd3) && s >= 3);
      eP0   = ((kind == 2'd3) && s >= 3) ? wd : selA[7:0];
      eP2Oe = extF || dat;
      eP2   = selA[15:8];
      if (aoff) chk("R9 ale held low", ale, 0);
      else if (dat) chk("R6 ale skip", ale, eAle);
      else chk("R3 ale", ale, eAle);
      if (kind == 2'd1 && !ext) chk("R5 psen idle", psenN, 1);
      else chk("R4 psen", psenN, !ePsen);
      chk("R7 rdN", rdN, !eRd);
      chk("R7 wrN", wrN, !eWr);
      chk("R11 p0Oe", p0Oe, eP0Oe);
      if (eP0Oe) chk((kind == 2'd3 && s >= 3) ? "R8 wdata" : "R3 p0 addr", p0Out, eP0);
      chk("R10 p2Oe", p2Oe, eP2Oe);
      if (eP2Oe) chk("R10 p2 value", p2Out, eP2);
      // R2: take request only in final clock; present an idle request mid-cycle
      if (k == 1) begin
        reqKind = 2'd0;
        reqValid = 1'b1;
      end
      if (k >= 1) begin
        #1;
        chk("R2 R1 reqTake at boundary", reqTake, (k == nClk - 1));
      end
    end
    @(negedge clk);
    reqValid = 1'b0;
    if (extF) expRd = {memByte(a1), memByte(addr)};
    else if (kind == 2'd2) expRd = {8'h00, memByte(addr)};
    chk("R2 busDone", busDone, (kind != 2'd0));
    chk("R12 rdData", rdData, expRd);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin : stim
    logic [15:0] addrs[2];
    addrs[0] = 16'h12FF;
    addrs[1] = 16'hA53C;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // Reset state
    chk("R2 reset busDone", busDone, 0);
    chk("R4 reset psenN", psenN, 1);
    chk("R7 reset rdN", rdN, 1);
    chk("R7 reset wrN", wrN, 1);
    chk("R11 reset p0Oe", p0Oe, 0);
    chk("R10 reset p2Oe", p2Oe, 0);
    chk("R12 reset rdData", rdData, 0);
    for (int m = 0; m < 2; m++)
      for (int e = 0; e < 2; e++)
        for (int ao = 0; ao < 2; ao++)
          for (int kd = 0; kd < 4; kd++)
            for (int ai = 0; ai < 2; ai++)
              runCycle(2'(kd), addrs[ai], 8'(8'h5A + kd * 17 + ai), m[0], e[0], ao[0]);
    // R1: mode switch back and forth between back-to-back reads
    runCycle(2'd2, 16'h0F0F, 8'h00, 1'b1, 1'b1, 1'b0);
    runCycle(2'd2, 16'hF00F, 8'h00, 1'b0, 1'b1, 1'b0);
    runCycle(2'd1, 16'hFFFF, 8'h00, 1'b1, 1'b1, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule